// File: doc/BRIEF.md
# Codec control command decoder

This block reads the control channel of a voice codec's serial frame. That channel carries one control byte into the device and one control byte out of it in every frame. A strobe marks each inbound byte. The block sorts every byte it decodes into one of four command classes. Write commands are followed by a payload, which the block stores into a small bank of configuration registers or into a coefficient memory. Read commands are answered with the requested bytes on the outbound control byte, one byte per frame, starting with the frame after the command.

Two devices can share one serial port. Each command therefore carries a device-select bit, which is compared with a strap input. When a write is meant for the other device, this device still counts past its payload, so those bytes are never mistaken for commands. The filter datapath that uses the coefficients lies outside this block. The configuration registers and the power-state bit are brought out as plain outputs.

Top module: `codec_ctl_dec`

## Requirements
- R1: After reset, `tx_ctl` is 8'h00, `cfg_out` is all zeros and `pwr_up` is 0.
- R2: Bits [3:2] of a decoded byte select its class: 2'b00 no-operation, 2'b01 status, 2'b10 coefficient, 2'b11 reserved. No-operation and reserved bytes change nothing, and the next byte is decoded as a command.
- R3: The block takes `rx_ctl` only in cycles where `frame_tick` is high. `tx_ctl`, `cfg_out` and `pwr_up` change only on the clock edge that samples such a cycle.
- R4: A status write is {bit7 = device select, bit6 = 0, bit5 = power, bit4 = 0, bits[3:2] = 2'b01, bits[1:0] = count-1}. The next count bytes are written to configuration registers 0 up to count-1, in that order. Register k appears on `cfg_out[8k+7:8k]` one cycle after the tick that carried its byte.
- R5: Bit 5 of a status write addressed to this device is copied to `pwr_up` on the command's tick. A status read leaves `pwr_up` unchanged.
- R6: A status read (bit6 = 1) of count bytes puts register 0 on `tx_ctl` after the command's tick. Each later tick moves `tx_ctl` on to the next register.
- R7: A coefficient command is {bit7 = device select, bit6 = read, bits[5:4] = code[3:2], bits[3:2] = 2'b10, bits[1:0] = code[1:0]}. Codes 0 to 9 carry 8 bytes and codes 10 and 11 carry 4 bytes. A write stores its payload in that code's block, and a read returns the block in stored order.
- R8: Coefficient codes 12 to 15 are ignored. No payload is taken for them, and the next byte is decoded as a command.
- R9: A command whose bit 7 differs from `dev_sel` has no effect. For a write, the block skips its full payload length without decoding those bytes as commands.
- R10: While a write payload is being taken, every byte is stored as data, including bytes that look like commands.
- R11: A read of N bytes issued at tick k ignores the bytes at ticks k+1 through k+N-1, with no write and no command. The byte at tick k+N is decoded as a command.
- R12: `tx_ctl` is 8'h00 at every frame in which no read data is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe marking a valid inbound control byte |
| rx_ctl | input | 8 | Inbound control byte |
| dev_sel | input | 1 | Strap level this device answers to |
| tx_ctl | output | 8 | Outbound control byte for the current frame |
| cfg_out | output | N_CFG*8 | Configuration registers, register k in bits [8k+7:8k] |
| pwr_up | output | 1 | Power-state bit from the last addressed status write |

## Verification
The hardest situations to reach are the ones where a byte that is a valid command must not be decoded. This happens while a payload is being collected, while a foreign write's payload is being skipped, and while a read response is still draining. The stimulus places addressed status-read commands in exactly those frames. The bench then watches `tx_ctl`: it must stay 8'h00 or continue the current response, and must not start a new answer. Right after the window closes, a one-byte read shows that the first byte past the window is decoded. Together these pin down the window length for every payload size.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

  // Field sizes fixed by the command encoding.
  localparam int CODE_W = 4;
  localparam int LEN_W  = 4;
  localparam int IDX_W  = 3;

  localparam logic [7:0] NOP_BYTE = 8'h00;

  typedef enum logic [1:0] {
    CLS_NOP  = 2'b00,
    CLS_STAT = 2'b01,
    CLS_COEF = 2'b10,
    CLS_RSV  = 2'b11
  } cmd_cls_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_COLLECT,
    SQ_SKIP,
    SQ_SEND
  } seq_state_e;

  typedef struct packed {
    logic              begin_wr;
    logic              begin_rd;
    logic              begin_skip;
    logic              to_coef;
    logic [CODE_W-1:0] code;
    logic [LEN_W-1:0]  len;
    logic              pwr_we;
    logic              pwr_val;
  } cmd_dec_t;

endpackage

// File: rtl/codec_ctl_cmd_decode.sv
module codec_ctl_cmd_decode
  import codec_ctl_pkg::*;
#(
  parameter int N_CFG     = 4,
  parameter int N_FILT    = 10,
  parameter int N_SHORT   = 2,
  parameter int FILT_LEN  = 8,
  parameter int SHORT_LEN = 4
) (
  input  logic [7:0] cmd,
  input  logic       dev_sel,
  output cmd_dec_t   dec
);

  localparam logic [CODE_W-1:0] FILT_END  = CODE_W'(N_FILT);
  localparam logic [CODE_W-1:0] SHORT_END = CODE_W'(N_FILT + N_SHORT);
  localparam logic [LEN_W-1:0]  FILT_L    = LEN_W'(FILT_LEN);
  localparam logic [LEN_W-1:0]  SHORT_L   = LEN_W'(SHORT_LEN);
  localparam logic [LEN_W-1:0]  CFG_L     = LEN_W'(N_CFG);
  localparam logic [LEN_W-1:0]  ONE_L     = LEN_W'(1);

  logic addr_ok;
  logic is_rd;
  logic valid;

  always_comb begin
    dec     = '0;
    valid   = 1'b0;
    addr_ok = (cmd[7] == dev_sel);
    is_rd   = cmd[6];
    unique case (cmd_cls_e'(cmd[3:2]))
      CLS_STAT: begin
        valid       = 1'b1;
        dec.to_coef = 1'b0;
        dec.len     = LEN_W'(cmd[1:0]) + ONE_L;
        if (dec.len > CFG_L) dec.len = CFG_L;
        dec.pwr_we  = addr_ok & ~is_rd;
        dec.pwr_val = cmd[5];
      end
      CLS_COEF: begin
        dec.to_coef = 1'b1;
        dec.code    = {cmd[5:4], cmd[1:0]};
        if (dec.code < FILT_END) begin
          valid   = 1'b1;
          dec.len = FILT_L;
        end else if (dec.code < SHORT_END) begin
          valid   = 1'b1;
          dec.len = SHORT_L;
        end
      end
      default: ;
    endcase
    dec.begin_wr   = valid &  addr_ok & ~is_rd;
    dec.begin_rd   = valid &  addr_ok &  is_rd;
    dec.begin_skip = valid & ~addr_ok & ~is_rd;
  end

endmodule

// File: rtl/codec_ctl_seq.sv
module codec_ctl_seq
  import codec_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  cmd_dec_t          dec,
  input  logic [7:0]        rd_data,
  output logic              mem_we,
  output logic              mem_to_coef,
  output logic [CODE_W-1:0] mem_code,
  output logic [IDX_W-1:0]  mem_idx,
  output logic              rd_to_coef,
  output logic [CODE_W-1:0] rd_code,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              pwr_we,
  output logic              pwr_val,
  output logic [7:0]        tx_ctl
);

  localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);
  localparam logic [IDX_W-1:0] ONE_I = IDX_W'(1);

  seq_state_e        st_q, st_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              coef_q, coef_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [7:0]        tx_q, tx_d;
  logic              accept;
  logic              load_rd;

  // Sequencing and read address; independent of the read data.
  always_comb begin
    st_d    = st_q;
    left_d  = left_q;
    idx_d   = idx_q;
    coef_d  = coef_q;
    code_d  = code_q;
    accept  = 1'b0;
    load_rd = 1'b0;
    mem_we  = 1'b0;
    if (tick) begin
      unique case (st_q)
        SQ_IDLE: accept = 1'b1;
        SQ_COLLECT: begin
          mem_we = 1'b1;
          idx_d  = idx_q + ONE_I;
          left_d = left_q - ONE_L;
          if (left_q == ONE_L) st_d = SQ_IDLE;
        end
        SQ_SKIP: begin
          left_d = left_q - ONE_L;
          if (left_q == ONE_L) st_d = SQ_IDLE;
        end
        SQ_SEND: begin
          if (left_q != '0) begin
            idx_d   = idx_q + ONE_I;
            left_d  = left_q - ONE_L;
            load_rd = 1'b1;
          end else begin
            st_d   = SQ_IDLE;
            accept = 1'b1;
          end
        end
        default: st_d = SQ_IDLE;
      endcase
      if (accept) begin
        if (dec.begin_wr) begin
          st_d   = SQ_COLLECT;
          left_d = dec.len;
          idx_d  = '0;
          coef_d = dec.to_coef;
          code_d = dec.code;
        end else if (dec.begin_rd) begin
          st_d    = SQ_SEND;
          left_d  = dec.len - ONE_L;
          idx_d   = '0;
          coef_d  = dec.to_coef;
          code_d  = dec.code;
          load_rd = 1'b1;
        end else if (dec.begin_skip) begin
          st_d   = SQ_SKIP;
          left_d = dec.len;
        end
      end
    end
  end

  // Outbound byte: queued read data, otherwise the no-operation value.
  always_comb begin
    tx_d = tx_q;
    if (tick) tx_d = load_rd ? rd_data : NOP_BYTE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      left_q <= '0;
      idx_q  <= '0;
      coef_q <= 1'b0;
      code_q <= '0;
      tx_q   <= NOP_BYTE;
    end else if (tick) begin
      st_q   <= st_d;
      left_q <= left_d;
      idx_q  <= idx_d;
      coef_q <= coef_d;
      code_q <= code_d;
      tx_q   <= tx_d;
    end
  end

  assign mem_to_coef = coef_q;
  assign mem_code    = code_q;
  assign mem_idx     = idx_q;
  assign rd_to_coef  = coef_d;
  assign rd_code     = code_d;
  assign rd_idx      = idx_d;
  assign pwr_we      = accept & dec.pwr_we;
  assign pwr_val     = dec.pwr_val;
  assign tx_ctl      = tx_q;

endmodule

// File: rtl/codec_ctl_store.sv
module codec_ctl_store
  import codec_ctl_pkg::*;
#(
  parameter int N_CFG    = 4,
  parameter int N_BLK    = 12,
  parameter int FILT_LEN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               we_coef,
  input  logic [CODE_W-1:0]  we_code,
  input  logic [IDX_W-1:0]   we_idx,
  input  logic [7:0]         wdata,
  input  logic               rd_coef,
  input  logic [CODE_W-1:0]  rd_code,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic               pwr_we,
  input  logic               pwr_val,
  output logic [7:0]         rd_data,
  output logic [N_CFG*8-1:0] cfg_flat,
  output logic               pwr_up
);

  localparam int MEM_DEPTH = N_BLK * FILT_LEN;
  localparam int AW        = $clog2(MEM_DEPTH);
  localparam int CW        = $clog2(N_CFG);

  logic [7:0]    cfg_rd [N_CFG];
  logic [7:0]    mem_rd [MEM_DEPTH];
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic          cfg_we;
  logic          coef_we;

  assign waddr   = AW'(we_code) * AW'(FILT_LEN) + AW'(we_idx);
  assign raddr   = AW'(rd_code) * AW'(FILT_LEN) + AW'(rd_idx);
  assign cfg_we  = we & ~we_coef;
  assign coef_we = we &  we_coef;

  for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
    logic [7:0] reg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              reg_q <= '0;
      else if (cfg_we && we_idx == IDX_W'(g))  reg_q <= wdata;
    end
    assign cfg_rd[g]          = reg_q;
    assign cfg_flat[8*g +: 8] = reg_q;
  end

  for (genvar g = 0; g < MEM_DEPTH; g++) begin : g_coef
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cell_q <= '0;
      else if (coef_we && waddr == AW'(g))    cell_q <= wdata;
    end
    assign mem_rd[g] = cell_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_coef) begin
      if (raddr < AW'(MEM_DEPTH)) rd_data = mem_rd[raddr];
    end else if (rd_idx < IDX_W'(N_CFG)) begin
      rd_data = cfg_rd[rd_idx[CW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwr_up <= 1'b0;
    else if (pwr_we) pwr_up <= pwr_val;
  end

endmodule

// File: rtl/codec_ctl_dec.sv
module codec_ctl_dec
  import codec_ctl_pkg::*;
#(
  parameter int N_CFG     = 4,
  parameter int N_FILT    = 10,
  parameter int N_SHORT   = 2,
  parameter int FILT_LEN  = 8,
  parameter int SHORT_LEN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_tick,
  input  logic [7:0]         rx_ctl,
  input  logic               dev_sel,
  output logic [7:0]         tx_ctl,
  output logic [N_CFG*8-1:0] cfg_out,
  output logic               pwr_up
);

  localparam int N_BLK = N_FILT + N_SHORT;

  cmd_dec_t          dec;
  logic              mem_we;
  logic              mem_to_coef;
  logic [CODE_W-1:0] mem_code;
  logic [IDX_W-1:0]  mem_idx;
  logic              rd_to_coef;
  logic [CODE_W-1:0] rd_code;
  logic [IDX_W-1:0]  rd_idx;
  logic              pwr_we;
  logic              pwr_val;
  logic [7:0]        rd_data;

  codec_ctl_cmd_decode #(
    .N_CFG(N_CFG), .N_FILT(N_FILT), .N_SHORT(N_SHORT),
    .FILT_LEN(FILT_LEN), .SHORT_LEN(SHORT_LEN)
  ) u_decode (
    .cmd(rx_ctl), .dev_sel(dev_sel), .dec(dec)
  );

  codec_ctl_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .dec(dec), .rd_data(rd_data),
    .mem_we(mem_we), .mem_to_coef(mem_to_coef), .mem_code(mem_code), .mem_idx(mem_idx),
    .rd_to_coef(rd_to_coef), .rd_code(rd_code), .rd_idx(rd_idx),
    .pwr_we(pwr_we), .pwr_val(pwr_val), .tx_ctl(tx_ctl)
  );

  codec_ctl_store #(
    .N_CFG(N_CFG), .N_BLK(N_BLK), .FILT_LEN(FILT_LEN)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(mem_we), .we_coef(mem_to_coef), .we_code(mem_code), .we_idx(mem_idx), .wdata(rx_ctl),
    .rd_coef(rd_to_coef), .rd_code(rd_code), .rd_idx(rd_idx),
    .pwr_we(pwr_we), .pwr_val(pwr_val),
    .rd_data(rd_data), .cfg_flat(cfg_out), .pwr_up(pwr_up)
  );

endmodule

// File: rtl/codec_ctl_chk.sv
module codec_ctl_chk #(
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_tick,
  input logic [7:0]       rx_ctl,
  input logic             dev_sel,
  input logic [7:0]       tx_ctl,
  input logic [CFG_W-1:0] cfg_out,
  input logic             pwr_up
);

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(tx_ctl));

  // R4
  cfg_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out) |-> $past(frame_tick));

  // R5
  pwr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_up) |-> $past(frame_tick && rx_ctl[3:2] == 2'b01 &&
                            rx_ctl[7] == dev_sel && !rx_ctl[6] && rx_ctl[5]));

  // R5
  pwr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_up) |-> $past(frame_tick && rx_ctl[3:2] == 2'b01 &&
                            rx_ctl[7] == dev_sel && !rx_ctl[6] && !rx_ctl[5]));

  // R11
  send_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ctl != 8'h00) |=> $stable(cfg_out));

endmodule

bind codec_ctl_dec codec_ctl_chk #(.CFG_W(N_CFG*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rx_ctl(rx_ctl),
  .dev_sel(dev_sel), .tx_ctl(tx_ctl), .cfg_out(cfg_out), .pwr_up(pwr_up)
);

// File: tb/codec_ctl_dec_test.sv
module codec_ctl_dec_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_CFG      = 4;
  localparam int N_VALID    = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             frame_tick;
  logic [7:0]       rx_ctl;
  logic             dev_sel;
  logic [7:0]       tx_ctl;
  logic [N_CFG*8-1:0] cfg_out;
  logic             pwr_up;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_cfg [N_CFG];
  logic [7:0] exp_coef [N_VALID][8];
  logic       exp_pwr;

  codec_ctl_dec uut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rx_ctl(rx_ctl),
    .dev_sel(dev_sel), .tx_ctl(tx_ctl), .cfg_out(cfg_out), .pwr_up(pwr_up)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] b, output logic [7:0] t);
    @(negedge clk);
    rx_ctl = b;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    rx_ctl = 8'hA5;
    t = tx_ctl;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] sop(input logic a, input logic rd, input logic pw, input int n);
    return {a, rd, pw, 1'b0, 2'b01, 2'(n - 1)};
  endfunction

  function automatic logic [7:0] cop(input logic a, input logic rd, input int code);
    logic [3:0] c = 4'(code);
    return {a, rd, c[3:2], 2'b10, c[1:0]};
  endfunction

  function automatic int clen(input int code);
    if (code < 10) return 8;
    if (code < 12) return 4;
    return 0;
  endfunction

  function automatic logic [31:0] cfg_pack();
    return {exp_cfg[3], exp_cfg[2], exp_cfg[1], exp_cfg[0]};
  endfunction

  task automatic wr_status(input logic a, input logic pw, input int n, input int base);
    logic [7:0] t;
    frame(sop(a, 1'b0, pw, n), t);
    chk("R12 tx idle on write cmd", t, 8'h00);
    if (a == dev_sel) exp_pwr = pw;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = 8'(base + k * 37 + 3);
      frame(d, t);
      chk("R12 tx idle during payload", t, 8'h00);
      if (a == dev_sel) exp_cfg[k] = d;
    end
  endtask

  task automatic rd_status(input string req, input int n);
    logic [7:0] t;
    frame(sop(dev_sel, 1'b1, ~exp_pwr, n), t);
    chk(req, t, exp_cfg[0]);
    for (int k = 1; k < n; k++) begin
      frame(8'h00, t);
      chk(req, t, exp_cfg[k]);
    end
    frame(8'h00, t);
    chk("R12 nop after response", t, 8'h00);
    chk("R5 read keeps power", pwr_up, exp_pwr);
  endtask

  task automatic wr_coef(input logic a, input int code, input int pass);
    logic [7:0] t;
    frame(cop(a, 1'b0, code), t);
    for (int k = 0; k < clen(code); k++) begin
      logic [7:0] d = 8'(code * 17 + k * 5 + pass * 29 + 1);
      frame(d, t);
      chk("R10 payload not decoded", t, 8'h00);
      if (a == dev_sel) exp_coef[code][k] = d;
    end
  endtask

  task automatic rd_coef(input int code);
    logic [7:0] t;
    frame(cop(dev_sel, 1'b1, code), t);
    chk("R7 coef read byte", t, exp_coef[code][0]);
    for (int k = 1; k < clen(code); k++) begin
      frame(8'h00, t);
      chk("R7 coef read byte", t, exp_coef[code][k]);
    end
    frame(8'h00, t);
    chk("R12 nop after coef read", t, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] t;
    rst_n = 1'b0;
    frame_tick = 1'b0;
    rx_ctl = 8'h00;
    dev_sel = 1'b0;
    exp_pwr = 1'b0;
    for (int i = 0; i < N_CFG; i++) exp_cfg[i] = 8'h00;
    for (int c = 0; c < N_VALID; c++)
      for (int k = 0; k < 8; k++) exp_coef[c][k] = 8'h00;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset tx", tx_ctl, 8'h00);
    chk("R1 reset cfg", cfg_out, 32'h0);
    chk("R1 reset pwr", pwr_up, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int s = 0; s < 2; s++) begin
      dev_sel = s[0];
      // R4 R6 sweep counts
      for (int n = 1; n <= N_CFG; n++) begin
        wr_status(dev_sel, n[0], n, n * 11 + s * 71);
        chk("R4 cfg_out after write", cfg_out, cfg_pack());
        chk("R5 power from write", pwr_up, exp_pwr);
        for (int m = 1; m <= N_CFG; m++) rd_status("R6 status read", m);
      end
      // R7 coefficient sweep, R8 reserved codes
      for (int c = 0; c < 16; c++) begin
        if (c < N_VALID) wr_coef(dev_sel, c, s);
        else begin
          frame(cop(dev_sel, 1'b0, c), t);
          chk("R8 reserved code tx", t, 8'h00);
          frame(sop(dev_sel, 1'b1, exp_pwr, 1), t);
          chk("R8 next byte decoded", t, exp_cfg[0]);
          frame(cop(dev_sel, 1'b1, c), t);
          chk("R8 reserved read tx", t, 8'h00);
        end
      end
      for (int c = 0; c < N_VALID; c++) rd_coef(c);

      // R2 reserved and no-op classes
      frame(8'hFC, t);
      chk("R2 reserved class tx", t, 8'h00);
      frame(8'hF3, t);
      chk("R2 nop class tx", t, 8'h00);
      frame(sop(dev_sel, 1'b1, exp_pwr, 1), t);
      chk("R2 next byte decoded", t, exp_cfg[0]);
      frame(8'h00, t);

      // R9 foreign write payload skipped, foreign read ignored
      frame(sop(~dev_sel, 1'b0, ~exp_pwr, 2), t);
      chk("R9 foreign cmd tx", t, 8'h00);
      frame(sop(dev_sel, 1'b1, exp_pwr, 4), t);
      chk("R9 skipped byte 1", t, 8'h00);
      frame(sop(dev_sel, 1'b1, exp_pwr, 4), t);
      chk("R9 skipped byte 2", t, 8'h00);
      frame(sop(dev_sel, 1'b1, exp_pwr, 1), t);
      chk("R9 decoded after skip", t, exp_cfg[0]);
      frame(8'h00, t);
      chk("R9 power untouched", pwr_up, exp_pwr);
      chk("R9 cfg untouched", cfg_out, cfg_pack());
      frame(cop(~dev_sel, 1'b0, 10), t);
      for (int k = 0; k < 4; k++) begin
        frame(cop(dev_sel, 1'b1, 0), t);
        chk("R9 foreign coef payload skipped", t, 8'h00);
      end
      frame(sop(~dev_sel, 1'b1, exp_pwr, 4), t);
      chk("R9 foreign read silent", t, 8'h00);
      frame(sop(dev_sel, 1'b1, exp_pwr, 1), t);
      chk("R9 decoded after foreign read", t, exp_cfg[0]);
      frame(8'h00, t);
      rd_coef(10);

      // R10 command-like payload stored as data
      frame(sop(dev_sel, 1'b0, exp_pwr, 2), t);
      frame(sop(dev_sel, 1'b1, 1'b0, 4), t);
      chk("R10 payload byte not a read", t, 8'h00);
      exp_cfg[0] = sop(dev_sel, 1'b1, 1'b0, 4);
      frame(cop(dev_sel, 1'b1, 3), t);
      chk("R10 payload byte not a read", t, 8'h00);
      exp_cfg[1] = cop(dev_sel, 1'b1, 3);
      chk("R10 cfg holds command bytes", cfg_out, cfg_pack());

      // R11 bytes during a response are ignored
      frame(sop(dev_sel, 1'b1, exp_pwr, 4), t);
      chk("R11 response byte 0", t, exp_cfg[0]);
      frame(sop(dev_sel, 1'b0, ~exp_pwr, 1), t);
      chk("R11 response byte 1", t, exp_cfg[1]);
      frame(8'h5A, t);
      chk("R11 response byte 2", t, exp_cfg[2]);
      frame(sop(dev_sel, 1'b0, ~exp_pwr, 1), t);
      chk("R11 response byte 3", t, exp_cfg[3]);
      frame(sop(dev_sel, 1'b1, exp_pwr, 1), t);
      chk("R11 decode at k+N", t, exp_cfg[0]);
      frame(8'h00, t);
      chk("R11 cfg untouched", cfg_out, cfg_pack());
      chk("R11 power untouched", pwr_up, exp_pwr);

      // R3 outputs hold between ticks while rx toggles
      @(negedge clk);
      rx_ctl = sop(dev_sel, 1'b1, exp_pwr, 2);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      for (int i = 0; i < 5; i++) begin
        rx_ctl = 8'(i * 53 + 4);
        @(negedge clk);
        chk("R3 tx held between ticks", tx_ctl, exp_cfg[0]);
        chk("R3 cfg held between ticks", cfg_out, cfg_pack());
      end
      frame(8'h00, t);
      chk("R3 next tick advances", t, exp_cfg[1]);
      frame(8'h00, t);
      chk("R12 idle after response", t, 8'h00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule